// File: doc/BRIEF.md
# System Timer with Per-Processor Mode Control

This block is the system-wide counter/timer of a multiprocessor timer complex. A free-running prescaler produces one count tick every 500 ns, and a 22-bit counter steps up once per tick. When the counter reaches the programmed limit it returns to zero, sets a sticky reached flag and raises the system interrupt. Software clears the flag and the interrupt by reading the limit register. The limit has two write locations: one also restarts the count and one leaves the count running.

The block also holds a mode register with one bit per processor. A set bit places that processor's own timer in user (free-running counter) mode. On each write to the mode register the block sends two kinds of single-cycle pulse out to the processor timers. An interrupt-clear pulse goes to every processor whose bit is written as one. A restart pulse goes to every processor whose bit changed value. The processor timers themselves sit outside this block.

Registers are 32-bit words in a 0x14-byte window, selected by byte address bits 4:2. Reads return data one cycle after the request.

Top module: `sys_timer_ctl`

## Requirements
- R1: After reset, irq is 0, cpu_user_mode, cpu_restart and cpu_irq_clear are all 0, and a limit read returns 0x7FFFFE00.
- R2: While running, the count moves up by one (0x200 in the read word) every TICK_CYCLES clock cycles, counted from the last write at byte offset 0x00.
- R3: On the tick where the count equals limit minus one, the count returns to 0 and both the reached flag and irq become 1. irq stays 1 until it is cleared.
- R4: A read at offset 0x00 returns the limit in bits 30:9 with every other bit zero, and it clears the reached flag and irq. If a wrap happens on the same edge, the wrap wins.
- R5: A read at offset 0x04 returns the reached flag in bit 31, the count in bits 30:9 and zeros in bits 8:0. The read has no side effect.
- R6: A write at offset 0x00 loads the limit from wdata bits 30:9, ignoring bits 31 and 8:0. It also zeroes the count, the prescaler and the reached flag, and it drops irq.
- R7: A limit written with bits 30:9 all zero is stored as 0x7FFFFE00.
- R8: A write at offset 0x08 loads the limit the same way but leaves the count and prescaler running. If the running count is already at or above the new limit minus one, the next tick wraps.
- R9: A write at offset 0x10 stores wdata bits NCPU-1:0 as the mode register. The register drives cpu_user_mode and reads back zero-extended at 0x10.
- R10: After a mode write, cpu_irq_clear is high for exactly one cycle on each processor whose bit was written as 1.
- R11: After a mode write, cpu_restart is high for exactly one cycle on each processor whose mode bit changed.
- R12: Reads at 0x0C or at any offset of 0x14 and above return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | System timer interrupt |
| cpu_user_mode | output | NCPU | Per-processor user-mode select |
| cpu_restart | output | NCPU | Per-processor restart pulse |
| cpu_irq_clear | output | NCPU | Per-processor interrupt-clear pulse |

## Verification
Several properties are checked on every cycle. irq never stands without the reached flag, and the stored limit is never zero. A restart pulse always equals the change seen on the mode outputs. Clear pulses appear only after a mode write and only on user-mode processors. A reset write or a limit read leaves irq low on the next cycle. Exact count values, the wrap timing for a given limit and tick length, the masking of written fields, the no-reset limit write, and the zero reads outside the window can only be shown by the bench. It compares read words against a model of tick and wrap edges, using both random limits and directed sequences.

// File: rtl/sys_tmr_pkg.sv
package sys_tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int FRAC_BITS = 9;
  localparam int CNT_W     = DATA_W - 1 - FRAC_BITS;

  localparam logic [2:0] IDX_LIMIT    = 3'd0;
  localparam logic [2:0] IDX_COUNT    = 3'd1;
  localparam logic [2:0] IDX_LIMIT_NR = 3'd2;
  localparam logic [2:0] IDX_MODE     = 3'd4;
endpackage

// File: rtl/sys_tick_gen.sv
module sys_tick_gen #(
  parameter int TICK_CYCLES = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_clr,
  output logic tick
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre;

  assign tick = (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || sync_clr || tick) pre <= '0;
    else                         pre <= pre + 1'b1;
  end
endmodule

// File: rtl/sys_count.sv
module sys_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_limit,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             reset_count,
  input  logic             clear_reached,
  output logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             reached,
  output logic             irq,
  output logic             wrap
);
  logic [CNT_W-1:0] limit_fix;

  assign limit_fix = (limit_in == '0) ? '1 : limit_in;
  assign wrap      = tick && !reset_count && (count >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit   <= '1;
      count   <= '0;
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (load_limit) limit <= limit_fix;

      if (reset_count)  count <= '0;
      else if (wrap)    count <= '0;
      else if (tick)    count <= count + 1'b1;

      if (wrap)                              reached <= 1'b1;
      else if (clear_reached || reset_count) reached <= 1'b0;

      if (wrap)                              irq <= 1'b1;
      else if (clear_reached || reset_count) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/sys_mode_ctrl.sv
module sys_mode_ctrl #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [NCPU-1:0] wbits,
  output logic [NCPU-1:0] mode,
  output logic [NCPU-1:0] restart,
  output logic [NCPU-1:0] irq_clear
);
  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) begin
        mode[i]      <= 1'b0;
        restart[i]   <= 1'b0;
        irq_clear[i] <= 1'b0;
      end else begin
        restart[i]   <= wr && (wbits[i] != mode[i]);
        irq_clear[i] <= wr && wbits[i];
        if (wr) mode[i] <= wbits[i];
      end
    end
  end
endmodule

// File: rtl/sys_timer_ctl.sv
module sys_timer_ctl
  import sys_tmr_pkg::*;
#(
  parameter int NCPU        = 4,
  parameter int TICK_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [NCPU-1:0]   cpu_user_mode,
  output logic [NCPU-1:0]   cpu_restart,
  output logic [NCPU-1:0]   cpu_irq_clear
);
  logic [2:0]        reg_idx;
  logic              wr_lim_rst, wr_lim_run, wr_mode, rd_lim;
  logic              tick, wrap, reached;
  logic [CNT_W-1:0]  limit, count;
  logic [DATA_W-1:0] rd_next;
  logic              unused_bits;

  assign reg_idx    = addr[ADDR_W-1:2];
  assign wr_lim_rst = wr_en && (reg_idx == IDX_LIMIT);
  assign wr_lim_run = wr_en && (reg_idx == IDX_LIMIT_NR);
  assign wr_mode    = wr_en && (reg_idx == IDX_MODE);
  assign rd_lim     = rd_en && (reg_idx == IDX_LIMIT);
  assign unused_bits = ^{wdata[DATA_W-1], wdata[FRAC_BITS-1:0], addr[1:0]};

  sys_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .sync_clr (wr_lim_rst),
    .tick     (tick)
  );

  sys_count #(.CNT_W(CNT_W)) u_count (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .load_limit    (wr_lim_rst || wr_lim_run),
    .limit_in      (wdata[DATA_W-2:FRAC_BITS]),
    .reset_count   (wr_lim_rst),
    .clear_reached (rd_lim),
    .limit         (limit),
    .count         (count),
    .reached       (reached),
    .irq           (irq),
    .wrap          (wrap)
  );

  sys_mode_ctrl #(.NCPU(NCPU)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_mode),
    .wbits     (wdata[NCPU-1:0]),
    .mode      (cpu_user_mode),
    .restart   (cpu_restart),
    .irq_clear (cpu_irq_clear)
  );

  always_comb begin
    case (reg_idx)
      IDX_LIMIT, IDX_LIMIT_NR: rd_next = {1'b0, limit, {FRAC_BITS{1'b0}}};
      IDX_COUNT:               rd_next = {reached, count, {FRAC_BITS{1'b0}}};
      IDX_MODE:                rd_next = DATA_W'(cpu_user_mode);
      default:                 rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/sys_timer_ctl_chk.sv
module sys_timer_ctl_chk #(
  parameter int NCPU  = 4,
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [4:0]       addr,
  input logic             irq,
  input logic             reached,
  input logic             wrap,
  input logic [CNT_W-1:0] limit,
  input logic [CNT_W-1:0] count,
  input logic [NCPU-1:0]  cpu_user_mode,
  input logic [NCPU-1:0]  cpu_restart,
  input logic [NCPU-1:0]  cpu_irq_clear
);
  AST_IRQ_NEEDS_REACHED: assert property (@(posedge clk) disable iff (rst)
    irq |-> reached); // R3

  AST_LIMIT_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    limit != '0); // R7

  AST_RESET_WRITE_ZEROES: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && addr[4:2] == 3'd0) |-> (count == '0) && !irq && !reached); // R6

  AST_LIMIT_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr[4:2] == 3'd0 && !wrap) |-> !irq && !reached); // R4

  AST_CLEAR_ONLY_USER: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq_clear & ~cpu_user_mode) == '0); // R10

  AST_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq_clear != '0) |-> $past(wr_en && addr[4:2] == 3'd4)); // R10

  AST_RESTART_IS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (cpu_restart != '0) |-> cpu_restart == (cpu_user_mode ^ $past(cpu_user_mode))); // R11

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && addr[4:2] == 3'd4) |-> $stable(cpu_user_mode) && cpu_restart == '0); // R9
endmodule

bind sys_timer_ctl sys_timer_ctl_chk #(.NCPU(NCPU), .CNT_W(sys_tmr_pkg::CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .rd_en         (rd_en),
  .addr          (addr),
  .irq           (irq),
  .reached       (reached),
  .wrap          (wrap),
  .limit         (limit),
  .count         (count),
  .cpu_user_mode (cpu_user_mode),
  .cpu_restart   (cpu_restart),
  .cpu_irq_clear (cpu_irq_clear)
);

// File: tb/test_sys_timer_ctl.sv
module test_sys_timer_ctl;
  localparam int NCPU = 4;
  localparam int T    = 4;
  localparam logic [NCPU-1:0] MASK = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [NCPU-1:0] cpu_user_mode, cpu_restart, cpu_irq_clear;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  logic [NCPU-1:0] m_mode = '0;

  sys_timer_ctl #(.NCPU(NCPU), .TICK_CYCLES(T)) i_sys_timer_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .cpu_user_mode(cpu_user_mode),
    .cpu_restart(cpu_restart), .cpu_irq_clear(cpu_irq_clear)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output int e);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; e = cyc;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output int e);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata; e = cyc;
  endtask

  // state after edge 'edge_n': wraps happen at wedge + k*L*T
  function automatic logic flag_at(int wedge, int clr, int edge_n, int lim);
    int k = (edge_n - wedge) / (lim * T);
    return (k >= 1) && ((wedge + k * lim * T) >= clr);
  endfunction

  function automatic logic [31:0] count_word(int wedge, int clr, int redge, int lim);
    int m = redge - 1 - wedge;
    int c = (m / T) % lim;
    return {flag_at(wedge, clr, redge - 1, lim), 22'(c), 9'b0};
  endfunction

  task automatic cfg(input logic [31:0] d);
    int e;
    logic [NCPU-1:0] nb;
    nb = d[NCPU-1:0] & MASK;
    wr(5'h10, d, e);
    chk("R9 mode out", 32'(cpu_user_mode), 32'(nb));
    chk("R10 clear pulse", 32'(cpu_irq_clear), 32'(nb));
    chk("R11 restart pulse", 32'(cpu_restart), 32'(nb ^ m_mode));
    m_mode = nb;
    @(negedge clk);
    chk("R10 R11 pulses one cycle", 32'({cpu_irq_clear, cpu_restart}), 32'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int we, re, clr, lim;
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'(0));
    chk("R1 outs", 32'({cpu_user_mode, cpu_restart, cpu_irq_clear}), 32'(0));
    rd(5'h00, d, re); chk("R1 limit", d, 32'h7FFFFE00);
    rd(5'h10, d, re); chk("R1 mode read", d, 32'h0);

    // R6 masked load, R2 count, R3 wrap, R4 clear, R5 format
    lim = 5;
    wr(5'h00, 32'h80000A00 | 32'h1FF, we);
    rd(5'h00, d, re); chk("R6 R4 limit masked", d, 32'h00000A00);
    clr = re;
    rd(5'h04, d, re); chk("R2 R5 count early", d, count_word(we, clr, re, lim));
    repeat (8) @(negedge clk);
    rd(5'h04, d, re); chk("R2 count mid", d, count_word(we, clr, re, lim));
    while (cyc < we + lim * T) @(negedge clk);
    chk("R3 irq after wrap", 32'(irq), 32'(flag_at(we, clr, cyc, lim)));
    rd(5'h04, d, re); chk("R3 R5 reached word", d, count_word(we, clr, re, lim));
    rd(5'h00, d, re); clr = re;
    chk("R4 irq cleared", 32'(irq), 32'(flag_at(we, clr, re, lim)));
    rd(5'h04, d, re); chk("R4 reached cleared", d, count_word(we, clr, re, lim));
    wr(5'h00, 32'h00000A00, we);
    chk("R6 irq dropped", 32'(irq), 32'(0));

    // R7 zero limit, R8 no-reset limit write
    wr(5'h00, 32'h000001FF, we);
    rd(5'h00, d, re); chk("R7 zero limit", d, 32'h7FFFFE00);
    wr(5'h00, 32'(1000) << 9, we);
    repeat (40) @(negedge clk);
    wr(5'h08, 32'h0, re);
    rd(5'h04, d, re); chk("R8 count kept", d, count_word(we, we, re, 32'h3FFFFF));
    rd(5'h08, d, re); chk("R7 R8 limit via 0x08", d, 32'h7FFFFE00);
    wr(5'h00, 32'(1000) << 9, we);
    repeat (40) @(negedge clk);
    wr(5'h08, 32'h00000600, re);
    repeat (T + 1) @(negedge clk);
    chk("R8 shrink wraps", 32'(irq), 32'(1));

    // R12 holes and out-of-window
    wr(5'h00, 32'h00000A00, we);
    cfg(32'h5);
    wr(5'h0C, 32'hFFFFFFFF, re);
    wr(5'h14, 32'h0, re);
    wr(5'h18, 32'hFFFFFFFF, re);
    wr(5'h1C, 32'h0, re);
    rd(5'h0C, d, re); chk("R12 read 0x0C", d, 32'h0);
    rd(5'h14, d, re); chk("R12 read 0x14", d, 32'h0);
    rd(5'h1C, d, re); chk("R12 read 0x1C", d, 32'h0);
    rd(5'h10, d, re); chk("R12 mode kept", d, 32'h5);
    rd(5'h08, d, re); chk("R12 limit kept", d, 32'h00000A00);

    // R9 masking and readback
    cfg(32'hFFFFFFF2);
    rd(5'h10, d, re); chk("R9 mode masked read", d, 32'h2);

    // random mix
    for (int i = 0; i < 24; i++) begin
      lim = 2 + int'($urandom_range(5));
      wr(5'h00, (32'(lim) << 9) | ($urandom & 32'h800001FF), we);
      repeat ($urandom_range(60)) @(negedge clk);
      rd(5'h04, d, re); chk("R2 R3 R5 random count", d, count_word(we, we, re, lim));
      chk("R3 random irq", 32'(irq), 32'(flag_at(we, we, re, lim)));
      cfg($urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule